// File: doc/BRIEF.md
# Sleep-Aware Serial ADC Host Controller

This block is the host side of a link to a serial analog-to-digital converter whose frame runs for sixteen falling edges of a serial clock. It accepts conversion and sleep commands on a valid/ready handshake. For each command it drives the converter's chip-select and serial clock, and it shifts in the converter's data line. Each completed conversion becomes a right-aligned parallel sample, marked by a one-cycle valid pulse.

To put the converter to sleep, the controller starts a frame and deliberately stops it after the fourth falling edge. To wake it, a conversion command issued while the controller believes the converter is asleep first runs a full dummy frame whose data is discarded. The real conversion follows after the usual quiet gap, so the sample consumer only ever sees genuine results. The serial clock is an integer division of the system clock. The sample resolution (12, 10 or 8 bits) is chosen per command.

Top module: `adc_sleep_host`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs settle to cs_n=1, sclk=1, smp_valid=0, cmd_ready=1 and asleep=1. A converter of unknown state is therefore treated as asleep.
- R2: A conversion frame holds cs_n low across exactly 16 falling edges of sclk. Consecutive falling edges are 2*CLK_DIV system cycles apart, and sclk is high whenever cs_n is high.
- R3: A sleep command accepted while awake runs a frame that releases cs_n after exactly 4 falling edges. It produces no sample and sets asleep to 1 in the same cycle cs_n rises.
- R4: Between any two frames, cs_n stays high for at least 2 sclk periods (4*CLK_DIV system cycles).
- R5: A conversion command accepted while asleep runs a full 16-edge dummy frame, then one real frame. Exactly one sample results, the dummy frame's data never appears, and asleep is 0 afterwards.
- R6: The data line is sampled at the system edge on which sclk falls, so the bit presented before each falling edge is the bit captured for that edge.
- R7: The sample is straight binary of N bits, formed from the bits of falling edges 2 through N+1 with the first of these as the MSB, right-aligned in smp_data, with all higher bits zero. cmd_res encodes N: 00 gives 12, 01 gives 10, 10 gives 8, 11 gives 12.
- R8: smp_valid is a single-cycle pulse that rises in the same cycle in which cs_n returns high at the end of a real conversion frame.
- R9: A sleep command accepted while already asleep causes no frame: cs_n stays high, asleep stays 1 and cmd_ready stays 1.
- R10: cmd_ready is high only while no frame or quiet gap is in progress. A command is taken when cmd_valid and cmd_ready are both high, and cmd_res is captured at that moment, so later changes to it do not affect that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_sleep | input | 1 | 1 = sleep command, 0 = conversion command |
| cmd_res | input | 2 | Resolution select for a conversion (see R7) |
| cmd_ready | output | 1 | Controller can take a command |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Converter serial clock, idles high |
| sdata_in | input | 1 | Serial data from the converter |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | 16 | Right-aligned sample |
| asleep | output | 1 | Controller's view of the converter power state |

## Verification
Assertions check several rules on every cycle: the edge count at each chip-select release (16 or 4), the minimum quiet gap before each new frame, sclk high while deselected, the sample strobe coinciding with the chip-select rise, zero upper bits at the chosen resolution, and the asleep flag rising only when a frame ends. Only the bench's scenarios can show the rest. These are that the dummy frame's data is withheld and exactly one real sample follows a wake, that the bit order and alignment of each resolution match the converter's serial stream, that a second sleep command starts no frame, and that the resolution is captured at acceptance.

// File: rtl/adc_host_pkg.sv
// Package: shared types and helpers for the serial ADC host controller.
// Assumes nothing beyond the two-bit resolution code described in the brief.
package adc_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_QUIET
    } host_st_t;

    typedef enum logic [1:0] {
        FK_CONV,
        FK_DUMMY,
        FK_ABORT
    } frame_kind_t;

    // Map the resolution select code onto a sample width in bits.
    function automatic int unsigned res_bits(input logic [1:0] sel);
        case (sel)
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
// Module: adc_sclk_gen
// Produces the serial clock by dividing the system clock, together with
// strobes marking the system edge on which sclk falls or rises.
// Assumes: run stays high for a whole frame. sclk parks high while run is low.
module adc_sclk_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic             tick;

    assign tick     = run && (div_cnt == DIV_W'(CLK_DIV - 1));
    assign fall_stb = tick && sclk;
    assign rise_stb = tick && !sclk;

    // Half-period counter, held at zero outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // Serial clock level: toggles on each half-period, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sclk <= 1'b1;
        end else if (tick) begin
            sclk <= ~sclk;
        end
    end

endmodule

// File: rtl/adc_rx_shift.sv
// Module: adc_rx_shift
// Shifts in one data bit per sclk falling edge and presents the
// right-aligned sample for the selected resolution.
// Assumes: the frame carries WORD_W edges and the code starts at edge 2.
module adc_rx_shift
    import adc_host_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              sdata,
    input  logic [1:0]        res_sel,
    output logic [WORD_W-1:0] aligned
);
    logic [WORD_W-1:0] sr;

    // Capture register: cleared between frames, filled MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr <= '0;
        end else if (shift) begin
            sr <= {sr[WORD_W-2:0], sdata};
        end
    end

    // Alignment: drop the leading edge bit and the trailing bits, mask the rest.
    always_comb begin
        int unsigned       n;
        logic [WORD_W-1:0] shifted;
        logic [WORD_W-1:0] mask;
        n       = res_bits(res_sel);
        shifted = sr >> (WORD_W - 1 - n);
        mask    = (WORD_W'(1) << n) - WORD_W'(1);
        aligned = shifted & mask;
    end

endmodule

// File: rtl/adc_sleep_host.sv
// Module: adc_sleep_host (top)
// Sequences conversion, abort-to-sleep and dummy wake-up frames on a
// serial ADC link and returns real samples only.
// Assumes: sdata_in is stable around the system edge on which sclk falls.
module adc_sleep_host
    import adc_host_pkg::*;
#(
    parameter int CLK_DIV       = 2,
    parameter int FRAME_EDGES   = 16,
    parameter int ABORT_EDGE    = 4,
    parameter int QUIET_PERIODS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_sleep,
    input  logic [1:0]             cmd_res,
    output logic                   cmd_ready,
    output logic                   cs_n,
    output logic                   sclk,
    input  logic                   sdata_in,
    output logic                   smp_valid,
    output logic [FRAME_EDGES-1:0] smp_data,
    output logic                   asleep
);
    localparam int CNT_W     = $clog2(FRAME_EDGES + 1);
    localparam int QUIET_CYC = QUIET_PERIODS * 2 * CLK_DIV;
    localparam int Q_W       = $clog2(QUIET_CYC + 1);

    host_st_t                st;
    frame_kind_t             kind;
    logic [1:0]              res_q;
    logic [CNT_W-1:0]        fall_cnt;
    logic [CNT_W-1:0]        edge_limit;
    logic [Q_W-1:0]          quiet_cnt;
    logic                    pend_conv;
    logic                    run;
    logic                    fall_stb;
    logic                    rise_stb;
    logic                    frame_done;
    logic                    accept;
    logic [FRAME_EDGES-1:0]  aligned;

    assign run        = (st == ST_FRAME);
    assign cmd_ready  = (st == ST_IDLE);
    assign accept     = cmd_valid && cmd_ready;
    assign edge_limit = (kind == FK_ABORT) ? CNT_W'(ABORT_EDGE) : CNT_W'(FRAME_EDGES);
    assign frame_done = run && rise_stb && (fall_cnt == edge_limit);

    adc_sclk_gen #(
        .CLK_DIV (CLK_DIV)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    adc_rx_shift #(
        .WORD_W (FRAME_EDGES)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!run),
        .shift   (fall_stb),
        .sdata   (sdata_in),
        .res_sel (res_q),
        .aligned (aligned)
    );

    // Frame sequencer: command intake, frame end handling, quiet gap, wake chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= FK_CONV;
            res_q     <= 2'b00;
            fall_cnt  <= '0;
            quiet_cnt <= '0;
            pend_conv <= 1'b0;
            cs_n      <= 1'b1;
            asleep    <= 1'b1;
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        res_q <= cmd_res;
                        if (!cmd_sleep || !asleep) begin
                            st       <= ST_FRAME;
                            cs_n     <= 1'b0;
                            fall_cnt <= '0;
                            if (cmd_sleep) begin
                                kind <= FK_ABORT;
                            end else if (asleep) begin
                                kind      <= FK_DUMMY;
                                pend_conv <= 1'b1;
                            end else begin
                                kind <= FK_CONV;
                            end
                        end
                    end
                end
                ST_FRAME: begin
                    if (fall_stb) begin
                        fall_cnt <= fall_cnt + CNT_W'(1);
                    end
                    if (frame_done) begin
                        cs_n      <= 1'b1;
                        st        <= ST_QUIET;
                        quiet_cnt <= '0;
                        case (kind)
                            FK_CONV: begin
                                smp_valid <= 1'b1;
                                smp_data  <= aligned;
                            end
                            FK_DUMMY: asleep <= 1'b0;
                            default:  asleep <= 1'b1;
                        endcase
                    end
                end
                default: begin
                    if (quiet_cnt == Q_W'(QUIET_CYC - 1)) begin
                        if (pend_conv) begin
                            pend_conv <= 1'b0;
                            kind      <= FK_CONV;
                            st        <= ST_FRAME;
                            cs_n      <= 1'b0;
                            fall_cnt  <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        quiet_cnt <= quiet_cnt + Q_W'(1);
                    end
                end
            endcase
        end
    end

    // Checker support: cycles cs_n has been high, saturating at the quiet minimum.
    logic [Q_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= Q_W'(QUIET_CYC);
        end else if (!cs_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt < Q_W'(QUIET_CYC)) begin
            hi_cnt <= hi_cnt + Q_W'(1);
        end
    end

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt == CNT_W'(FRAME_EDGES) || fall_cnt == CNT_W'(ABORT_EDGE)))
        else $error("edge count at release"); // R2
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk) else $error("sclk low while deselected"); // R2
    AST_SLEEP_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $rose(cs_n)) else $error("asleep set off frame end"); // R3
    AST_QUIET_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= Q_W'(QUIET_CYC))) else $error("quiet gap short"); // R4
    AST_AWAKE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !asleep) else $error("sample while asleep"); // R5
    AST_SAMPLE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((smp_data >> res_bits(res_q)) == '0)) else $error("upper bits set"); // R7
    AST_SAMPLE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> $rose(cs_n)) else $error("sample strobe misplaced"); // R8
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (cs_n && sclk)) else $error("ready during frame"); // R10

endmodule

// File: tb/adc_sleep_host_tb.sv
`timescale 1ns/1ps
module adc_sleep_host_tb;
    localparam int DIV  = 3;
    localparam int QCYC = 4 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_sleep = 1'b0;
    logic [1:0]  cmd_res = 2'b00;
    logic        sdata_in = 1'b1;
    logic        cmd_ready, cs_n, sclk, smp_valid, asleep;
    logic [15:0] smp_data;

    adc_sleep_host #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sleep(cmd_sleep),
        .cmd_res(cmd_res), .cmd_ready(cmd_ready), .cs_n(cs_n), .sclk(sclk),
        .sdata_in(sdata_in), .smp_valid(smp_valid), .smp_data(smp_data), .asleep(asleep)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int exp_q[$];
    int len_q[$];
    int code_q[$];
    int nbit_q[$];
    int cur_code = 0, cur_n = 12, falls = 0, last_fall = 0, hi_cycles = 0;
    int starts = 0, samples = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    bit   seen_frame = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Converter model: bit for edge k. Edge 1 and edges past the code carry 1s.
    function automatic logic bit_for(input int k, input int code, input int n);
        if (k < 2 || k > n + 1) return 1'b1;
        return code[n - k + 1];
    endfunction

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // Reference monitor and converter model, evaluated every cycle away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(cs_n && !sclk), "R2", "sclk low while deselected", sclk, 1);
            if (prev_cs && !cs_n) begin
                starts++;
                if (seen_frame) chk(hi_cycles >= QCYC, "R4", "quiet gap cycles", hi_cycles, QCYC);
                seen_frame = 1'b1;
                falls = 0;
                if (code_q.size() > 0) begin
                    cur_code = code_q.pop_front();
                    cur_n    = nbit_q.pop_front();
                end else begin
                    cur_code = 'hFFF;
                    cur_n    = 12;
                end
                sdata_in = bit_for(1, cur_code, cur_n);
            end
            if (!cs_n && prev_sclk && !sclk) begin
                falls++;
                if (falls > 1) chk(cyc - last_fall == 2 * DIV, "R2", "falling edge spacing",
                                   cyc - last_fall, 2 * DIV);
                last_fall = cyc;
                sdata_in = bit_for(falls + 1, cur_code, cur_n);
            end
            if (!prev_cs && cs_n) begin
                len_q.push_back(falls);
                hi_cycles = 1;
            end else if (cs_n) begin
                hi_cycles++;
            end
            if (smp_valid) begin
                samples++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected sample", smp_data, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(smp_data == 16'(e), "R7", "sample value", smp_data, e);
                end
                chk(cs_n && !prev_cs, "R8", "strobe at cs_n rise", cs_n, 1);
            end
            prev_cs   = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic send(input bit slp, input logic [1:0] res, input logic [1:0] res_after);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_sleep = slp;
        cmd_res   = res;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_res   = res_after;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_frames(input int a, input int b, input string req);
        int want;
        want = (b < 0) ? 1 : 2;
        chk(len_q.size() == want, req, "frame count", len_q.size(), want);
        if (len_q.size() > 0) chk(len_q[0] == a, req, "first frame edges", len_q[0], a);
        if (want == 2 && len_q.size() > 1) chk(len_q[1] == b, req, "second frame edges", len_q[1], b);
        len_q.delete();
    endtask

    task automatic push_frame(input int code, input int n);
        code_q.push_back(code);
        nbit_q.push_back(n);
    endtask

    initial begin
        int s0;
        int st0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
        chk(smp_valid == 1'b0, "R1", "smp_valid in reset", smp_valid, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
        chk(asleep == 1'b1, "R1", "asleep in reset", asleep, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5/R6: first conversion wakes with a dummy frame, data withheld
        push_frame('hA5A, 12);
        push_frame('h3C5, 12);
        exp_q.push_back('h3C5);
        send(1'b0, 2'b00, 2'b00);
        wait_idle();
        expect_frames(16, 16, "R5");
        chk(samples == 1, "R5", "samples after wake", samples, 1);
        chk(asleep == 1'b0, "R5", "asleep after wake", asleep, 0);

        // R7/R10: 10-bit sample, select changed after acceptance
        push_frame('h2B7, 10);
        exp_q.push_back('h2B7);
        send(1'b0, 2'b01, 2'b10);
        wait_idle();
        expect_frames(16, -1, "R2");
        chk(samples == 2, "R10", "samples", samples, 2);

        // R7/R6: 8-bit sample
        push_frame('hC3, 8);
        exp_q.push_back('hC3);
        send(1'b0, 2'b10, 2'b00);
        wait_idle();
        expect_frames(16, -1, "R2");

        // R7: code 11 selects 12 bits, full-scale code
        push_frame('hFFF, 12);
        exp_q.push_back('hFFF);
        send(1'b0, 2'b11, 2'b00);
        wait_idle();
        expect_frames(16, -1, "R7");

        // R7: zero code
        push_frame('h000, 12);
        exp_q.push_back('h000);
        send(1'b0, 2'b00, 2'b00);
        wait_idle();
        expect_frames(16, -1, "R7");

        // R3: sleep aborts after the fourth edge, no sample
        s0 = samples;
        send(1'b1, 2'b00, 2'b00);
        wait_idle();
        expect_frames(4, -1, "R3");
        chk(asleep == 1'b1, "R3", "asleep after abort", asleep, 1);
        chk(samples == s0, "R3", "samples after abort", samples, s0);

        // R9: sleep while asleep starts no frame
        st0 = starts;
        send(1'b1, 2'b00, 2'b00);
        repeat (40) @(negedge clk);
        chk(starts == st0, "R9", "frames started", starts, st0);
        chk(asleep == 1'b1, "R9", "asleep held", asleep, 1);
        chk(cmd_ready == 1'b1, "R9", "ready held", cmd_ready, 1);

        // R5: wake again with 10-bit result
        push_frame('h3FF, 10);
        push_frame('h201, 10);
        exp_q.push_back('h201);
        s0 = samples;
        send(1'b0, 2'b01, 2'b01);
        wait_idle();
        expect_frames(16, 16, "R5");
        chk(samples == s0 + 1, "R5", "single sample on wake", samples, s0 + 1);

        // R4: back-to-back conversions, quiet gap checked by monitor
        push_frame('h800, 12);
        push_frame('h001, 12);
        exp_q.push_back('h800);
        exp_q.push_back('h001);
        send(1'b0, 2'b00, 2'b00);
        send(1'b0, 2'b00, 2'b00);
        wait_idle();
        expect_frames(16, 16, "R4");

        chk(exp_q.size() == 0, "R8", "samples outstanding", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule